// File: doc/BRIEF.md
# Serial sample output port for a sampling converter

This block is the digital side of the serial port of a 12-bit sampling converter. It runs on the serial clock, `sclk`. A parallel sample word, `sample_i`, stands in for the converter core. When chip select goes low, the block emits one conversion frame on `dout`. A frame is a run of leading zero bits followed by the sample word, most significant bit first. `status` marks the bit clocks of a frame, and the one-clock strobe `hold_o` marks the clock during which the sample is captured.

The block has two modes of use:

- **Slave use:** the host lowers chip select for each conversion and raises it afterwards.
- **Free-running use:** chip select stays low. Frames then repeat with one dead clock between them.

Deselecting the block or asserting shutdown clears all state at once and releases the output. A frame cut short this way carries no valid data.

The output bit register and all state registers change on the falling edge of `sclk`, so the host can sample `dout` on the rising edge. The control is a four-state machine:

| State | What happens |
|---|---|
| ST_SAMPLE | Reset state. Presents frame bit 1 (a zero) and captures the sample on its closing falling edge. |
| ST_LEAD | Presents the remaining leading zeros. |
| ST_DATA | Shifts out the sample bits. |
| ST_GAP | The dead clock(s), with `dout` driven low. |

The transitions are:

- ST_SAMPLE to ST_LEAD. If only one zero leads, ST_SAMPLE goes straight to ST_DATA.
- ST_LEAD to ST_DATA after the last zero.
- ST_DATA to ST_GAP after the last bit of the frame.
- ST_GAP to ST_SAMPLE after the dead clocks.
- Any state to ST_SAMPLE, asynchronously, when chip select goes high or shutdown is asserted.

The parameters set the shape of the frame: `DATA_W` sample bits, `LEAD_ZEROS` leading zeros (at least 1) and `GAP_CLKS` dead clocks (at least 1).

Top module: `adcser_port`

## Requirements
- R1: While `cs_n` is high, `dout_oe`, `status` and `hold_o` are low and all state is cleared. This holds asynchronously.
- R2: On the first rising `sclk` edge after `cs_n` falls, frame bit 1 (a zero) is on `dout`, and `status` and `hold_o` are high. `hold_o` is high for that one clock only.
- R3: The sample captured is the `sample_i` value present at the falling edge that closes the hold clock. Changes to `sample_i` after that edge do not alter the bits of the current frame.
- R4: With the defaults, a frame has 16 bit clocks. Rising edges 1 to 4 carry 0. Rising edges 5 to 16 carry `sample_i[11]` down to `sample_i[0]`, in that order.
- R5: `dout` changes only on falling edges of `sclk`. It is stable from one falling edge across the following rising edge.
- R6: `status` is high on all 16 bit clocks of a frame and low on the dead clock that follows.
- R7: While `cs_n` stays low, frames repeat every 17 clocks. On the dead clock `dout` is driven low with `dout_oe` high. The next rising edge is bit 1 of a new frame that captures a fresh sample.
- R8: Asserting `shdn` drops `dout_oe` and `status` at once, without waiting for a clock edge. When `shdn` is released with `cs_n` still low, a new frame begins at bit 1 on the next rising edge.
- R9: Raising `cs_n` in the middle of a frame aborts it. The next fall of `cs_n` starts a complete new frame at bit 1 with a newly captured sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. State changes on its falling edge. |
| cs_n | input | 1 | Active-low chip select. High clears the block asynchronously. |
| shdn | input | 1 | Shutdown. High aborts and clears the block asynchronously. |
| sample_i | input | DATA_W | Parallel sample word from the converter model. |
| dout | output | 1 | Serial frame bit. |
| dout_oe | output | 1 | Output enable for `dout`. Low means high impedance. |
| status | output | 1 | High during the bit clocks of a conversion frame. |
| hold_o | output | 1 | Capture strobe, high during the clock whose closing edge latches the sample. |

## Verification
The bench builds the block with its defaults: 12 sample bits, four leading zeros and one dead clock. At that size every one of the 4096 sample codes fits into one free-running run of back-to-back frames. Each frame is checked against its code shifted behind four zeros. The run also changes the input just after each capture, which exercises R3 on every code. Short slave-mode runs cover deselection, a mid-frame chip-select abort and an asynchronous shutdown with restart.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

    // Conversion frame phases, advanced on the falling edge of sclk
    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,   // bit 1 presented, sample captured at its close
        ST_LEAD   = 2'd1,   // remaining leading zero bits
        ST_DATA   = 2'd2,   // sample bits, MSB first
        ST_GAP    = 2'd3    // dead clock(s) between frames
    } ser_state_e;

endpackage

// File: rtl/adcser_fsm.sv
module adcser_fsm
    import adcser_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int GAP_CLKS   = 1
) (
    input  logic       sclk,
    input  logic       abort,
    output ser_state_e state_q,
    output ser_state_e state_nxt,
    output logic       load
);

    localparam int FRAME_BITS = LEAD_ZEROS + DATA_W;
    localparam int CNT_MAX    = (FRAME_BITS > GAP_CLKS) ? FRAME_BITS : GAP_CLKS;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LEAD  = CNT_W'(LEAD_ZEROS);
    localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_GAP   = CNT_W'(GAP_CLKS);

    // cnt holds the 1-based bit position on dout, or the dead-clock index in ST_GAP
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        unique case (state_q)
            ST_SAMPLE: begin
                cnt_nxt   = cnt_q + CNT_ONE;
                state_nxt = (LEAD_ZEROS >= 2) ? ST_LEAD : ST_DATA;
            end
            ST_LEAD: begin
                cnt_nxt = cnt_q + CNT_ONE;
                if (cnt_q == CNT_LEAD) begin
                    state_nxt = ST_DATA;
                end
            end
            ST_DATA: begin
                if (cnt_q == CNT_FRAME) begin
                    state_nxt = ST_GAP;
                    cnt_nxt   = CNT_ONE;
                end else begin
                    cnt_nxt = cnt_q + CNT_ONE;
                end
            end
            ST_GAP: begin
                if (cnt_q == CNT_GAP) begin
                    state_nxt = ST_SAMPLE;
                    cnt_nxt   = CNT_ONE;
                end else begin
                    cnt_nxt = cnt_q + CNT_ONE;
                end
            end
            default: begin
                state_nxt = ST_SAMPLE;
                cnt_nxt   = CNT_ONE;
            end
        endcase
    end

    always_ff @(negedge sclk or posedge abort) begin
        if (abort) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= CNT_ONE;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // Capture happens on the edge that closes the bit-1 clock
    assign load = (state_q == ST_SAMPLE);

endmodule

// File: rtl/adcser_shift.sv
module adcser_shift #(
    parameter int DATA_W = 12
) (
    input  logic              sclk,
    input  logic              abort,
    input  logic              load,
    input  logic              drive_data,
    input  logic [DATA_W-1:0] sample_i,
    output logic              dout
);

    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] src;

    // A freshly loaded word and a word already held take the same path
    assign src = load ? sample_i : shreg_q;

    always_ff @(negedge sclk or posedge abort) begin
        if (abort) begin
            shreg_q <= '0;
            dout    <= 1'b0;
        end else if (drive_data) begin
            dout    <= src[DATA_W-1];
            shreg_q <= {src[DATA_W-2:0], 1'b0};
        end else begin
            dout    <= 1'b0;
            shreg_q <= src;
        end
    end

endmodule

// File: rtl/adcser_port.sv
module adcser_port
    import adcser_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int GAP_CLKS   = 1
) (
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              shdn,
    input  logic [DATA_W-1:0] sample_i,
    output logic              dout,
    output logic              dout_oe,
    output logic              status,
    output logic              hold_o
);

    logic       abort;
    ser_state_e state_q;
    ser_state_e state_nxt;
    logic       load;
    logic       drive_data;

    // Deselect and shutdown both clear the block without a clock
    assign abort = cs_n | shdn;

    adcser_fsm #(
        .DATA_W     (DATA_W),
        .LEAD_ZEROS (LEAD_ZEROS),
        .GAP_CLKS   (GAP_CLKS)
    ) u_fsm (
        .sclk      (sclk),
        .abort     (abort),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .load      (load)
    );

    assign drive_data = (state_nxt == ST_DATA);

    adcser_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .sclk       (sclk),
        .abort      (abort),
        .load       (load),
        .drive_data (drive_data),
        .sample_i   (sample_i),
        .dout       (dout)
    );

    always_comb begin
        dout_oe = !abort;
        status  = !abort && (state_q != ST_GAP);
        hold_o  = !abort && (state_q == ST_SAMPLE);
    end

endmodule

// File: rtl/adcser_chk.sv
module adcser_chk (
    input logic sclk,
    input logic cs_n,
    input logic shdn,
    input logic dout,
    input logic dout_oe,
    input logic status,
    input logic hold_o
);

    // R1
    deselect_quiet_chk: assert property (@(posedge sclk)
        cs_n |-> (!dout_oe && !status && !hold_o));

    // R8
    shutdown_quiet_chk: assert property (@(posedge sclk)
        shdn |-> (!dout_oe && !status));

    // R2
    hold_single_chk: assert property (@(posedge sclk) disable iff (cs_n || shdn)
        hold_o |=> !hold_o);

    // R2
    frame_starts_hold_chk: assert property (@(posedge sclk) disable iff (cs_n || shdn)
        $rose(status) |-> hold_o);

    // R4
    first_bit_zero_chk: assert property (@(posedge sclk) disable iff (cs_n || shdn)
        hold_o |-> !dout);

    // R6
    capture_then_busy_chk: assert property (@(posedge sclk) disable iff (cs_n || shdn)
        hold_o |=> status);

    // R7
    dead_clock_low_chk: assert property (@(posedge sclk) disable iff (cs_n || shdn)
        (dout_oe && !status) |-> (!dout && !hold_o));

endmodule

bind adcser_port adcser_chk u_chk (
    .sclk    (sclk),
    .cs_n    (cs_n),
    .shdn    (shdn),
    .dout    (dout),
    .dout_oe (dout_oe),
    .status  (status),
    .hold_o  (hold_o)
);

// File: tb/adcser_port_tb_top.sv
`timescale 1ns/1ps
module adcser_port_tb_top;

    localparam int DW = 12;

    logic          sclk = 1'b1;
    logic          cs_n = 1'b1;
    logic          shdn = 1'b0;
    logic [DW-1:0] sample_i = '0;
    logic          dout;
    logic          dout_oe;
    logic          status;
    logic          hold_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 sclk = ~sclk;

    adcser_port dut_i (
        .sclk     (sclk),
        .cs_n     (cs_n),
        .shdn     (shdn),
        .sample_i (sample_i),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .status   (status),
        .hold_o   (hold_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reads bits 1..16 at rising edges; changes sample_i to alt after the capture edge
    task automatic read_frame(input logic [DW-1:0] alt, output logic [15:0] w,
                              output int bad_stat, output int bad_stab, output int bad_hold);
        w = '0; bad_stat = 0; bad_stab = 0; bad_hold = 0;
        for (int k = 1; k <= 16; k++) begin
            logic d1;
            @(posedge sclk); #1;
            d1 = dout;
            w = {w[14:0], dout};
            if (!status || !dout_oe) bad_stat++;
            if (hold_o != (k == 1)) bad_hold++;
            if (k == 2) sample_i = alt;
            #2;
            if (dout !== d1) bad_stab++;
        end
    endtask

    task automatic frame_checks(input logic [DW-1:0] v, input logic [15:0] w,
                                input int bs, input int bb, input int bh, input string tag);
        chk(w == {4'b0000, v}, {tag, " R4 frame word"}, w, {4'b0000, v});
        chk(bs == 0, {tag, " R6 status/oe over frame"}, bs, 0);
        chk(bb == 0, {tag, " R5 dout stable across rising edge"}, bb, 0);
        chk(bh == 0, {tag, " R2 hold strobe only on bit 1"}, bh, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge sclk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] w;
        int bs, bb, bh;

        repeat (3) @(posedge sclk);
        #1;
        // R1 deselected reset state
        chk(!dout_oe && !status && !hold_o, "R1 deselected outputs",
            {dout_oe, status, hold_o}, 0);

        // Slave frame with input change after capture (R2, R3, R4)
        @(negedge sclk); #2;
        sample_i = 12'hA5C;
        cs_n = 1'b0;
        read_frame(12'h3A3, w, bs, bb, bh);
        frame_checks(12'hA5C, w, bs, bb, bh, "slave R3");
        @(posedge sclk); #1;
        chk(!status && dout_oe && !dout, "R6 dead clock after slave frame",
            {status, dout_oe, dout}, 3'b010);
        @(negedge sclk); #2;
        cs_n = 1'b1;
        #1;
        chk(!dout_oe && !status, "R1 deselect releases output", {dout_oe, status}, 0);

        // R9 mid-frame chip-select abort then fresh frame
        @(negedge sclk); #2;
        sample_i = 12'hFFF;
        cs_n = 1'b0;
        repeat (7) @(posedge sclk);
        #2;
        cs_n = 1'b1;
        #1;
        chk(!dout_oe && !status, "R9 abort clears outputs", {dout_oe, status}, 0);
        @(negedge sclk); #2;
        sample_i = 12'h081;
        cs_n = 1'b0;
        read_frame(12'hF7E, w, bs, bb, bh);
        frame_checks(12'h081, w, bs, bb, bh, "after abort R9");

        // R8 asynchronous shutdown mid-frame, then restart while selected
        @(negedge sclk); #2;
        cs_n = 1'b1;
        @(negedge sclk); #2;
        sample_i = 12'h6D2;
        cs_n = 1'b0;
        repeat (9) @(posedge sclk);
        #2;
        shdn = 1'b1;
        #1;
        chk(!dout_oe && !status && !hold_o, "R8 shutdown is immediate",
            {dout_oe, status, hold_o}, 0);
        @(negedge sclk); #2;
        sample_i = 12'h935;
        shdn = 1'b0;
        read_frame(12'h000, w, bs, bb, bh);
        frame_checks(12'h935, w, bs, bb, bh, "after shutdown R8");

        // R7 free-running exhaustive sweep over all sample codes
        @(negedge sclk); #2;
        cs_n = 1'b1;
        @(negedge sclk); #2;
        sample_i = '0;
        cs_n = 1'b0;
        for (int v = 0; v < 4096; v++) begin
            int gap_bad;
            read_frame(~DW'(v), w, bs, bb, bh);
            frame_checks(DW'(v), w, bs, bb, bh, "free-run R7");
            @(posedge sclk); #1;
            gap_bad = (status || !dout_oe || dout || hold_o) ? 1 : 0;
            chk(gap_bad == 0, "R7 single dead clock driven low",
                {status, dout_oe, dout, hold_o}, 4'b0100);
            sample_i = DW'(v + 1);
        end

        cs_n = 1'b1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule